// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a full-duplex serial slave that lets a host controller program a small bank of configuration registers and, in the same transfer, read back a status word. Each transfer is one byte long. The host pulls the active-low select line low, toggles the serial clock eight times and raises the select line again. While it does so, the slave collects a command byte from the serial input and sends the status byte on the serial output, most significant bit first in both directions.

The command byte is split into two fields. The upper nibble picks one of the configuration registers and the lower nibble is the value to store. A register is written only when the select line goes high at the end of a transfer, and only if a whole number of bytes was clocked in. The status word is taken when the select line goes low, so later changes on the status bus do not affect the byte being shifted out.

The serial pins are brought into the system clock domain through two-flop synchronizers, and all edge detection runs in that domain. The system clock must therefore run at least four times faster than the serial clock. The serial output comes with an enable that an external pad can use to tri-state the line.

Top module: `spi_reg_slave`

## Requirements
- R1: While `rstN` is low, every field of `regOut` reads 0 and `soEn` reads 0.
- R2: `soEn` is 1 during a transfer (`csN` low) and returns to 0 after `csN` rises.
- R3: At the falling edge of `csN`, the value on `statusIn` is captured. Its bit 7 appears on `so` before the first SCLK rising edge. A later change on `statusIn` within the same transfer does not alter the byte shifted out.
- R4: `so` moves on to the next lower status bit on each SCLK rising edge that follows an SCLK falling edge. The first rising edge after `csN` falls leaves `so` unchanged. Once all eight status bits have been sent, `so` reads 0.
- R5: `si` is sampled on SCLK falling edges. The first sampled bit becomes bit 7 of the received byte.
- R6: When `csN` rises after exactly 8·k SCLK falling edges (k ≥ 1), the received byte's bits [7:4] select register A and bits [3:0] are stored in it. Register A appears on `regOut[4*A+3:4*A]`. `regOut` changes at no other time.
- R7: A received address of NUM_REGS or higher (6 to 15 by default) changes no register.
- R8: A transfer with a number of SCLK falling edges that is zero or not a multiple of 8 writes no register.
- R9: In a transfer of 16 falling edges, the last eight bits received are the byte that is committed.
- R10: While `csN` is high, activity on `sclk` and `si` writes nothing and shifts nothing. The next transfer is received correctly from its own first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| si | input | 1 | Serial data from the host |
| csN | input | 1 | Active-low select; changes only while sclk is low |
| statusIn | input | 8 | Status word captured when a transfer starts |
| so | output | 1 | Serial data to the host |
| soEn | output | 1 | Drive enable for the serial output pad |
| regOut | output | 24 | Configuration registers, NUM_REGS fields of 4 bits each |

## Verification
The bench builds the block with its defaults: 8-bit frames, a 4-bit address, 4-bit data and six implemented registers. Because only six registers exist, addresses 6 to 15 are reachable and can be checked as ignored alongside the live ones. The serial clock runs at one sixteenth of the system clock, so every synchronizer delay fits inside a half period. This leaves room for the test patterns: zero-length, short, nine-bit and double-length frames, and clocking while deselected.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Single-cycle strobes from the control unit to the datapath
  typedef struct packed {
    logic loadStatus;  // capture status word into the transmit shifter
    logic shiftIn;     // take rxBit into the receive shifter
    logic shiftOut;    // advance the transmit shifter by one bit
    logic commit;      // write the received byte to the addressed register
    logic rxBit;       // synchronized serial input bit
  } spiStrobe_t;

endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RST_VAL}};
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int FRAME_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       si,
  input  logic       csN,
  output spiStrobe_t strb,
  output logic       soEn
);

  localparam int CNT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic sclkS, siS, csS;
  logic sclkD, csD;
  logic csFall, csRise, active;
  logic sclkFall, sclkRise;
  logic [CNT_W-1:0] bitCnt;
  logic byteSeen;
  logic fallPend;

  spi_reg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncSclk (
    .clk(clk), .rstN(rstN), .d(sclk), .q(sclkS));
  spi_reg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncSi (
    .clk(clk), .rstN(rstN), .d(si), .q(siS));
  spi_reg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syncCs (
    .clk(clk), .rstN(rstN), .d(csN), .q(csS));

  // One extra stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD <= 1'b0;
      csD   <= 1'b1;
    end else begin
      sclkD <= sclkS;
      csD   <= csS;
    end
  end

  assign csFall   = csD & ~csS;
  assign csRise   = ~csD & csS;
  assign active   = ~csD & ~csS;
  assign sclkFall = active & sclkD & ~sclkS;
  assign sclkRise = active & ~sclkD & sclkS;

  // Bit counter and frame-alignment state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      byteSeen <= 1'b0;
      fallPend <= 1'b0;
    end else if (csFall) begin
      bitCnt   <= '0;
      byteSeen <= 1'b0;
      fallPend <= 1'b0;
    end else if (sclkFall) begin
      fallPend <= 1'b1;
      if (bitCnt == LAST_BIT) begin
        bitCnt   <= '0;
        byteSeen <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end else if (sclkRise) begin
      fallPend <= 1'b0;
    end
  end

  always_comb begin
    strb.loadStatus = csFall;
    strb.shiftIn    = sclkFall;
    strb.shiftOut   = sclkRise & fallPend;
    strb.commit     = csRise & byteSeen & (bitCnt == '0);
    strb.rxBit      = siS;
  end

  assign soEn = active;

endmodule

// File: rtl/spi_reg_dpath.sv
module spi_reg_dpath
  import spi_reg_pkg::*;
#(
  parameter int FRAME_W  = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 4,
  parameter int NUM_REGS = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  spiStrobe_t                 strb,
  input  logic [FRAME_W-1:0]         statusIn,
  input  logic                       soEn,
  output logic                       so,
  output logic [ADDR_W-1:0]          wrAddr,
  output logic [NUM_REGS*DATA_W-1:0] regOut
);

  logic [FRAME_W-1:0] txShift;
  logic [FRAME_W-1:0] rxShift;
  logic [DATA_W-1:0]  wrData;

  // Transmit shifter: parallel load of status, MSB out first, zero fill
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              txShift <= '0;
    else if (strb.loadStatus) txShift <= statusIn;
    else if (strb.shiftOut)   txShift <= {txShift[FRAME_W-2:0], 1'b0};
  end

  // Receive shifter: first bit in ends up in the MSB
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxShift <= '0;
    else if (strb.shiftIn) rxShift <= {rxShift[FRAME_W-2:0], strb.rxBit};
  end

  assign wrAddr = rxShift[FRAME_W-1 -: ADDR_W];
  assign wrData = rxShift[DATA_W-1:0];
  assign so     = soEn & txShift[FRAME_W-1];

  // Register bank: one field per implemented address
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [DATA_W-1:0] field;
    logic              hit;

    assign hit = strb.commit & (wrAddr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)  field <= '0;
      else if (hit) field <= wrData;
    end

    assign regOut[g*DATA_W +: DATA_W] = field;
  end

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int FRAME_W     = 8,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 4,
  parameter int NUM_REGS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclk,
  input  logic                       si,
  input  logic                       csN,
  input  logic [FRAME_W-1:0]         statusIn,
  output logic                       so,
  output logic                       soEn,
  output logic [NUM_REGS*DATA_W-1:0] regOut
);

  spiStrobe_t        strb;
  logic [ADDR_W-1:0] wrAddr;

  spi_reg_ctrl #(
    .FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .si(si), .csN(csN),
    .strb(strb), .soEn(soEn)
  );

  spi_reg_dpath #(
    .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .statusIn(statusIn), .soEn(soEn),
    .so(so), .wrAddr(wrAddr), .regOut(regOut)
  );

endmodule

// File: rtl/spi_reg_chk.sv
module spi_reg_chk #(
  parameter int FRAME_W  = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 4,
  parameter int NUM_REGS = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       csN,
  input logic [FRAME_W-1:0]         statusIn,
  input logic                       so,
  input logic                       soEn,
  input logic [NUM_REGS*DATA_W-1:0] regOut,
  input logic                       loadStatus,
  input logic                       shiftIn,
  input logic                       commit,
  input logic [ADDR_W-1:0]          wrAddr
);

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regOut) |-> $past(commit)); // R6

  AST_SOEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !soEn); // R2

  AST_UNIMPL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (commit && (int'(wrAddr) >= NUM_REGS)) |=> $stable(regOut)); // R7

  AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    loadStatus |=> (!soEn || so == $past(statusIn[FRAME_W-1]))); // R3

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !shiftIn); // R10

endmodule

bind spi_reg_slave spi_reg_chk #(
  .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .statusIn(statusIn), .so(so),
  .soEn(soEn), .regOut(regOut), .loadStatus(strb.loadStatus),
  .shiftIn(strb.shiftIn), .commit(strb.commit), .wrAddr(wrAddr)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;

  localparam int NREG = 6;
  localparam int RW   = NREG * 4;
  localparam int NVEC = 10;

  // {command byte, status byte}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h1A_A5, 16'h05_3C, 16'h5F_81, 16'h2C_7E, 16'h6B_FF,
    16'hF3_00, 16'h33_5A, 16'h49_C3, 16'h1E_01, 16'h00_80
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic si = 1'b0;
  logic csN = 1'b1;
  logic [7:0] statusIn = 8'h00;
  logic so, soEn;
  logic [RW-1:0] regOut;

  int checks = 0;
  int errors = 0;
  logic [3:0] mdl [NREG];
  logic [15:0] got;

  always #2.5 clk = ~clk;

  spi_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .si(si), .csN(csN),
    .statusIn(statusIn), .so(so), .soEn(soEn), .regOut(regOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] mdlFlat();
    logic [RW-1:0] f;
    for (int g = 0; g < NREG; g++) f[g*4 +: 4] = mdl[g];
    return f;
  endfunction

  function automatic void mdlWrite(input logic [7:0] b);
    if (int'(b[7:4]) < NREG) mdl[b[7:4]] = b[3:0];
  endfunction

  // One transfer of nBits clocks; first 16 SO samples returned in got
  task automatic xfer(input logic [15:0] bits, input int nBits, input logic [7:0] stat);
    got = '0;
    statusIn = stat;
    #20;
    csN = 1'b0;
    #40;
    statusIn = ~stat;  // must not affect the captured word (R3)
    for (int i = 0; i < nBits; i++) begin
      si = bits[nBits-1-i];
      #20;
      sclk = 1'b1;
      #40;
      if (i < 16) got[15-i] = so;
      if (i == 0) chk("R2 soEn during transfer", 32'(soEn), 32'd1);
      sclk = 1'b0;
      #20;
    end
    #20;
    csN = 1'b1;
    #100;
    chk("R2 soEn after transfer", 32'(soEn), 32'd0);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int g = 0; g < NREG; g++) mdl[g] = 4'h0;
    #50;
    chk("R1 regOut in reset", 32'(regOut), 32'd0);
    chk("R1 soEn in reset", 32'(soEn), 32'd0);
    rstN = 1'b1;
    #50;

    // Table-driven frames: R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      xfer({8'h00, VEC[v][15:8]}, 8, VEC[v][7:0]);
      mdlWrite(VEC[v][15:8]);
      chk("R3/R4 status byte on so", 32'(got[15:8]), 32'(VEC[v][7:0]));
      chk("R5/R6/R7 register bank", 32'(regOut), 32'(mdlFlat()));
    end

    // R8: short frame of 5 bits is discarded
    xfer(16'h0004, 5, 8'h11);
    chk("R8 5-bit frame ignored", 32'(regOut), 32'(mdlFlat()));

    // R8: empty frame
    xfer(16'h0000, 0, 8'h22);
    chk("R8 empty frame ignored", 32'(regOut), 32'(mdlFlat()));

    // R8: 9-bit frame
    xfer(16'h0053, 9, 8'h33);
    chk("R8 9-bit frame ignored", 32'(regOut), 32'(mdlFlat()));

    // R9 and R4: 16-bit frame commits last byte, so goes to zero after status
    xfer(16'h3A2D, 16, 8'hB7);
    mdlWrite(8'h2D);
    chk("R9 last byte committed", 32'(regOut), 32'(mdlFlat()));
    chk("R4 status then zeros", 32'(got), 32'h0000B700);

    // R10: clocking while deselected
    si = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #40 sclk = 1'b1;
      #40 sclk = 1'b0;
    end
    #100;
    chk("R10 no write while deselected", 32'(regOut), 32'(mdlFlat()));
    chk("R10 soEn low while deselected", 32'(soEn), 32'd0);
    xfer(16'h0047, 8, 8'h6E);
    mdlWrite(8'h47);
    chk("R10 next frame aligned", 32'(regOut), 32'(mdlFlat()));
    chk("R10 next status byte", 32'(got[15:8]), 32'h6E);

    // R1: reset mid-run clears the bank
    rstN = 1'b0;
    #20;
    chk("R1 regOut cleared by reset", 32'(regOut), 32'd0);
    chk("R1 soEn low in reset", 32'(soEn), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule